// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the raster timing for interlaced standard-definition video. Two line standards are supported, a 525-line and a 625-line one. Each has normal or square-pixel horizontal sampling. A pixel-rate enable advances a pixel counter and a line counter. The counter values are decoded into horizontal sync, vertical sync, blanking, a field indicator and an active-video flag. The raw pixel and line counts are also brought out, so that downstream formatting logic can place samples without counting again.

The standard and sampling selections are captured only when a frame completes, or during reset. A frame that has begun is therefore never reshaped halfway through. All outputs come from state that is updated on the rising clock edge. The outputs stay aligned with the counts presented on the same cycle.

Top module: `raster_timing_gen`

## Requirements
- R1: During and right after synchronous reset, the pixel count is 0 and the line count is 1. FIELD is 0, HSYNC is 1 and BLANK is 1. The standard and sampling inputs present at reset are captured.
- R2: On every clock with pix_en high, the pixel count advances by one. After the last pixel of a line it returns to 0 and the line count increments. The line totals are set by parameter and default to 858 (525-line, normal), 780 (525-line, square), 864 (625-line, normal) and 944 (625-line, square). The inputs select the standard with std_sel (0 = 525 lines, 1 = 625 lines) and the sampling with sq_sel (1 = square pixels).
- R3: The line count runs from 1 to 525 in the 525-line standard and from 1 to 625 in the 625-line standard. After the last pixel of the last line it returns to line 1, pixel 0.
- R4: HSYNC is high exactly while the pixel count is below HSYNC_W (default 64).
- R5: Horizontally, a line is active only for pixel counts from (total − active) to total − 1. The active widths default to 720, 640, 720 and 768, in the same order as the totals in R2.
- R6: In the 525-line standard, lines 23–262 and 285–524 are active. Lines 1–22, 263–284 and 525 are not.
- R7: In the 625-line standard, lines 23–310 and 336–623 are active. Lines 1–22, 311–335, 624 and 625 are not.
- R8: FIELD is 0 on lines 1–262 and 1 on lines 263–525 in the 525-line standard. In the 625-line standard it is 0 on lines 1–312 and 1 on lines 313–625.
- R9: VSYNC is high on lines 4–6 of each field. These are absolute lines 4–6 and 266–268 in the 525-line standard, and 4–6 and 316–318 in the 625-line standard.
- R10: The active flag is high exactly when both the horizontal window and the line are active. BLANK is always its inverse, so the active flag is never high during horizontal or vertical blanking.
- R11: While pix_en is low, the pixel count, line count and every timing output hold their values.
- R12: A change of std_sel or sq_sel takes effect only at the start of the next frame, that is, at line 1, pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-rate enable |
| std_sel | input | 1 | Line standard: 0 = 525 lines, 1 = 625 lines |
| sq_sel | input | 1 | 1 = square-pixel sampling |
| h_count | output | HCNT_W | Pixel count within the line, from 0 |
| v_count | output | 10 | Line count within the frame, from 1 |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Blanking, high outside the active window |
| field | output | 1 | 0 = first field, 1 = second field |
| active | output | 1 | Active-video flag |

## Verification
The bench shrinks the horizontal totals through parameters but keeps the full line structure. It then walks every pixel of whole frames in all four standard and sampling combinations, comparing each output against an arithmetic model on every cycle. The field-edge lines are the main targets: 262/263, 284/285, 310/311, 312/313, 335/336 and 623/624. An off-by-one decode at any of them would show a wrong FIELD, VSYNC or active flag on exactly one line. The mode inputs are changed mid-frame, so a design that latched them early would shorten or lengthen lines before the frame ends. One frame is run with a gapped enable, which exposes any counter or output that moves without pix_en.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int VCNT_W = 10;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } line_std_e;

    typedef struct packed {
        line_std_e std;
        logic      sq;
    } raster_cfg_t;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic blank;
        logic field;
        logic active;
    } raster_flags_t;

    localparam logic [VCNT_W-1:0] LINES_525    = 10'd525;
    localparam logic [VCNT_W-1:0] LINES_625    = 10'd625;
    localparam logic [VCNT_W-1:0] F2_START_525 = 10'd263;
    localparam logic [VCNT_W-1:0] F2_START_625 = 10'd313;
    localparam logic [VCNT_W-1:0] ACT_FIRST    = 10'd23;
    localparam logic [VCNT_W-1:0] A1_LAST_525  = 10'd262;
    localparam logic [VCNT_W-1:0] A2_FIRST_525 = 10'd285;
    localparam logic [VCNT_W-1:0] A2_LAST_525  = 10'd524;
    localparam logic [VCNT_W-1:0] A1_LAST_625  = 10'd310;
    localparam logic [VCNT_W-1:0] A2_FIRST_625 = 10'd336;
    localparam logic [VCNT_W-1:0] A2_LAST_625  = 10'd623;
    localparam logic [VCNT_W-1:0] VS_FIRST     = 10'd4;
    localparam logic [VCNT_W-1:0] VS_LAST      = 10'd6;

    function automatic logic [VCNT_W-1:0] frame_lines(line_std_e s);
        return (s == STD_625) ? LINES_625 : LINES_525;
    endfunction

    function automatic logic [VCNT_W-1:0] second_field_start(line_std_e s);
        return (s == STD_625) ? F2_START_625 : F2_START_525;
    endfunction

    function automatic logic in_second_field(line_std_e s, logic [VCNT_W-1:0] v);
        return v >= second_field_start(s);
    endfunction

    // Line number counted from 1 inside the current field.
    function automatic logic [VCNT_W-1:0] line_in_field(line_std_e s, logic [VCNT_W-1:0] v);
        logic [VCNT_W-1:0] base;
        base = in_second_field(s, v) ? (second_field_start(s) - VCNT_W'(1)) : '0;
        return v - base;
    endfunction

    function automatic logic line_is_active(line_std_e s, logic [VCNT_W-1:0] v);
        logic [VCNT_W-1:0] l1, f2, l2;
        l1 = (s == STD_625) ? A1_LAST_625  : A1_LAST_525;
        f2 = (s == STD_625) ? A2_FIRST_625 : A2_FIRST_525;
        l2 = (s == STD_625) ? A2_LAST_625  : A2_LAST_525;
        return ((v >= ACT_FIRST) && (v <= l1)) || ((v >= f2) && (v <= l2));
    endfunction

endpackage

// File: rtl/raster_hcnt.sv
module raster_hcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] htot,
    output logic [W-1:0] h,
    output logic         line_end
);

    assign line_end = en && (h == (htot - W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            h <= '0;
        end else if (line_end) begin
            h <= '0;
        end else if (en) begin
            h <= h + W'(1);
        end
    end

    assert_h_in_line_R2: assert property (@(posedge clk) disable iff (rst)
        h < htot);

    assert_h_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(h));

endmodule

// File: rtl/raster_vcnt.sv
module raster_vcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         line_end,
    input  logic [W-1:0] vtot,
    output logic [W-1:0] v,
    output logic         frame_end
);

    assign frame_end = line_end && (v == vtot);

    always_ff @(posedge clk) begin
        if (rst) begin
            v <= W'(1);
        end else if (frame_end) begin
            v <= W'(1);
        end else if (line_end) begin
            v <= v + W'(1);
        end
    end

    assert_v_range_R3: assert property (@(posedge clk) disable iff (rst)
        (v >= W'(1)) && (v <= vtot));

    assert_v_step_R2: assert property (@(posedge clk) disable iff (rst)
        (line_end && !frame_end) |=> (v == $past(v) + W'(1)));

    assert_v_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(v));

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
#(
    parameter int HW      = 10,
    parameter int HSYNC_W = 64
) (
    input  raster_cfg_t          cfg,
    input  logic [HW-1:0]        h,
    input  logic [VCNT_W-1:0]    v,
    input  logic [HW-1:0]        htot,
    input  logic [HW-1:0]        hact,
    output raster_flags_t        flags
);

    localparam logic [HW-1:0] HS_END = HW'(HSYNC_W);

    logic [HW-1:0]     h_first;
    logic [VCNT_W-1:0] lif;
    logic              h_act;
    logic              v_act;

    always_comb begin
        h_first      = htot - hact;
        lif          = line_in_field(cfg.std, v);
        h_act        = (h >= h_first);
        v_act        = line_is_active(cfg.std, v);
        flags.hsync  = (h < HS_END);
        flags.vsync  = (lif >= VS_FIRST) && (lif <= VS_LAST);
        flags.field  = in_second_field(cfg.std, v);
        flags.active = h_act && v_act;
        flags.blank  = !(h_act && v_act);
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int HCNT_W      = 10,
    parameter int H_TOT_N525  = 858,
    parameter int H_ACT_N525  = 720,
    parameter int H_TOT_S525  = 780,
    parameter int H_ACT_S525  = 640,
    parameter int H_TOT_N625  = 864,
    parameter int H_ACT_N625  = 720,
    parameter int H_TOT_S625  = 944,
    parameter int H_ACT_S625  = 768,
    parameter int HSYNC_W     = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pix_en,
    input  logic                 std_sel,
    input  logic                 sq_sel,
    output logic [HCNT_W-1:0]    h_count,
    output logic [VCNT_W-1:0]    v_count,
    output logic                 hsync,
    output logic                 vsync,
    output logic                 blank,
    output logic                 field,
    output logic                 active
);

    localparam logic [HCNT_W-1:0] HT_N525 = HCNT_W'(H_TOT_N525);
    localparam logic [HCNT_W-1:0] HA_N525 = HCNT_W'(H_ACT_N525);
    localparam logic [HCNT_W-1:0] HT_S525 = HCNT_W'(H_TOT_S525);
    localparam logic [HCNT_W-1:0] HA_S525 = HCNT_W'(H_ACT_S525);
    localparam logic [HCNT_W-1:0] HT_N625 = HCNT_W'(H_TOT_N625);
    localparam logic [HCNT_W-1:0] HA_N625 = HCNT_W'(H_ACT_N625);
    localparam logic [HCNT_W-1:0] HT_S625 = HCNT_W'(H_TOT_S625);
    localparam logic [HCNT_W-1:0] HA_S625 = HCNT_W'(H_ACT_S625);

    raster_cfg_t         cfg;
    raster_cfg_t         cfg_in;
    raster_flags_t       flags;
    logic [HCNT_W-1:0]   htot;
    logic [HCNT_W-1:0]   hact;
    logic [VCNT_W-1:0]   vtot;
    logic                line_end;
    logic                frame_end;

    assign cfg_in = '{std: line_std_e'(std_sel), sq: sq_sel};

    // Selection is captured at reset and at each frame boundary only.
    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            cfg <= cfg_in;
        end
    end

    always_comb begin
        case ({cfg.std, cfg.sq})
            2'b00:   begin htot = HT_N525; hact = HA_N525; end
            2'b01:   begin htot = HT_S525; hact = HA_S525; end
            2'b10:   begin htot = HT_N625; hact = HA_N625; end
            default: begin htot = HT_S625; hact = HA_S625; end
        endcase
        vtot = frame_lines(cfg.std);
    end

    raster_hcnt #(.W(HCNT_W)) u_hcnt (
        .clk      (clk),
        .rst      (rst),
        .en       (pix_en),
        .htot     (htot),
        .h        (h_count),
        .line_end (line_end)
    );

    raster_vcnt #(.W(VCNT_W)) u_vcnt (
        .clk       (clk),
        .rst       (rst),
        .line_end  (line_end),
        .vtot      (vtot),
        .v         (v_count),
        .frame_end (frame_end)
    );

    raster_decode #(.HW(HCNT_W), .HSYNC_W(HSYNC_W)) u_decode (
        .cfg   (cfg),
        .h     (h_count),
        .v     (v_count),
        .htot  (htot),
        .hact  (hact),
        .flags (flags)
    );

    assign hsync  = flags.hsync;
    assign vsync  = flags.vsync;
    assign blank  = flags.blank;
    assign field  = flags.field;
    assign active = flags.active;

    assert_cfg_frame_only_R12: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cfg));

    assert_frame_restart_R3: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> ((h_count == '0) && (v_count == VCNT_W'(1))));

    assert_vsync_blank_R9: assert property (@(posedge clk) disable iff (rst)
        vsync |-> blank);

    assert_hsync_blank_R4: assert property (@(posedge clk) disable iff (rst)
        hsync |-> blank);

    assert_field_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(field) |-> ((h_count == '0) && (v_count == second_field_start(cfg.std))));

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(hsync) && $stable(vsync) && $stable(blank) && $stable(field)));

endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HCW = 10;
    localparam int HSW = 3;
    localparam int TN525 = 24, AN525 = 20;
    localparam int TS525 = 22, AS525 = 16;
    localparam int TN625 = 26, AN625 = 20;
    localparam int TS625 = 28, AS625 = 22;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst, pix_en, std_sel, sq_sel;
    logic [HCW-1:0] h_count;
    logic [9:0] v_count;
    logic hsync, vsync, blank, field, active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    int mh, mv, cyc;
    bit ms, mq, wrapped, last_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timing_gen #(
        .HCNT_W(HCW),
        .H_TOT_N525(TN525), .H_ACT_N525(AN525),
        .H_TOT_S525(TS525), .H_ACT_S525(AS525),
        .H_TOT_N625(TN625), .H_ACT_N625(AN625),
        .H_TOT_S625(TS625), .H_ACT_S625(AS625),
        .HSYNC_W(HSW)
    ) u_raster_timing_gen (
        .clk(clk), .rst(rst), .pix_en(pix_en), .std_sel(std_sel), .sq_sel(sq_sel),
        .h_count(h_count), .v_count(v_count), .hsync(hsync), .vsync(vsync),
        .blank(blank), .field(field), .active(active)
    );

    function automatic int e_tot(bit s, bit q);
        return s ? (q ? TS625 : TN625) : (q ? TS525 : TN525);
    endfunction

    function automatic int e_act(bit s, bit q);
        return s ? (q ? AS625 : AN625) : (q ? AS525 : AN525);
    endfunction

    function automatic bit e_vact(bit s, int v);
        if (s) return ((v >= 23 && v <= 310) || (v >= 336 && v <= 623));
        return ((v >= 23 && v <= 262) || (v >= 285 && v <= 524));
    endfunction

    function automatic bit e_field(bit s, int v);
        return s ? (v >= 313) : (v >= 263);
    endfunction

    function automatic bit e_vsync(bit s, int v);
        if (s) return ((v >= 4 && v <= 6) || (v >= 316 && v <= 318));
        return ((v >= 4 && v <= 6) || (v >= 266 && v <= 268));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s line=%0d pix=%0d actual=%0d expected=%0d", tag, mv, mh, act, exp);
        end
    endtask

    task automatic compare_all();
        bit ha, va;
        string tcnt;
        ha = (mh >= e_tot(ms, mq) - e_act(ms, mq));
        va = e_vact(ms, mv);
        if (!last_en) tcnt = "R11";
        else if ({ms, mq} != {std_sel, sq_sel}) tcnt = "R12";
        else tcnt = "R2";
        chk(tcnt, int'(h_count), mh);
        chk(last_en ? "R3" : "R11", int'(v_count), mv);
        chk("R4 hsync", int'(hsync), int'(mh < HSW));
        chk(va ? "R5 active" : (ms ? "R7 active" : "R6 active"), int'(active), int'(ha && va));
        chk("R10 blank", int'(blank), int'(!(ha && va)));
        chk("R8 field", int'(field), int'(e_field(ms, mv)));
        chk("R9 vsync", int'(vsync), int'(e_vsync(ms, mv)));
    endtask

    task automatic step(input bit en);
        pix_en = en;
        if (en) begin
            if (mh == e_tot(ms, mq) - 1) begin
                mh = 0;
                if (mv == (ms ? 625 : 525)) begin
                    mv = 1; ms = std_sel; mq = sq_sel; wrapped = 1;
                end else begin
                    mv++;
                end
            end else begin
                mh++;
            end
        end
        last_en = en;
        cyc++;
        @(negedge clk);
        compare_all();
    endtask

    // Run one full frame of the current selection; request the next one midway.
    task automatic run_frame(input bit ns, input bit nq, input bit gated);
        int n;
        n = 0;
        wrapped = 0;
        while (!wrapped) begin
            if (n == 3000) begin std_sel = ns; sq_sel = nq; end
            step(gated ? ((cyc % 3) != 0) : 1'b1);
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired before the run completed");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pix_en = 1'b0; std_sel = 1'b0; sq_sel = 1'b0;
        cyc = 0; last_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 pix", int'(h_count), 0);
        chk("R1 line", int'(v_count), 1);
        chk("R1 field", int'(field), 0);
        chk("R1 hsync", int'(hsync), 1);
        chk("R1 blank", int'(blank), 1);
        rst = 1'b0;
        mh = 0; mv = 1; ms = 1'b0; mq = 1'b0;
        @(negedge clk);
        compare_all();
        run_frame(1'b0, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 1'b0);
        run_frame(1'b1, 1'b1, 1'b0);
        run_frame(1'b0, 1'b0, 1'b0);
        run_frame(1'b0, 1'b0, 1'b1);
        // short tail with enable held low: R11
        repeat (20) step(1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule